// File: doc/BRIEF.md
# Start/Stop Trace Qualifier with Cross-Trigger

This block watches the bus state stream of a processor under emulation. Each cycle it may receive one bus state (address, data, status). It compares that state against two programmable conditions. Each condition has a value and a don't-care mask for every field. One condition opens a capture window and the other closes it, so a trace buffer downstream records only a short run of states around each event and not a long fill after one trigger. An optional per-window length limit closes the window early. A match on the opening condition also gives a one-clock trigger pulse. When break-on-trigger is enabled it also sets a sticky halt request toward run control, so trace and breakpoint act on the same event.

The bus input is a stream qualified by `bus_valid` and has no ready signal. The block observes the bus and must never stall it, so every state presented with `bus_valid` high is taken in that cycle and cannot be back-pressured. Cycles with `bus_valid` low carry no state. The trace memory and the halting logic sit outside this block. The outputs are a per-state store enable, the trigger pulse and the break request. All three are registered and refer to the state presented one clock earlier.

Top module: `trace_qualifier`

## Requirements
- R1: A condition matches a state when, in each of the three fields, every bit whose don't-care mask bit is 0 equals the programmed value bit. A mask bit of 1 makes that bit always compare true.
- R2: With the window closed, a valid state that matches the start condition is itself stored and opens the window, unless R4 or R6 closes it again at once.
- R3: While the window is open, every valid state is stored. The state that matches the stop condition is stored, and the window is closed after it.
- R4: With the window closed, a state that matches both conditions is stored once and the window stays closed.
- R5: A cycle with `bus_valid` low stores nothing, gives no trigger and leaves the window state and its count unchanged.
- R6: With `win_limit` = N (N > 0), a window stores at most N states, and the Nth stored state closes it. With `win_limit` = 0 there is no limit.
- R7: `trig_pulse` is high for exactly one clock after each valid state that matches the start condition, also while the window is already open. Such a match does not restart the window count.
- R8: `brk_req` is set by a start match while `brk_en` is 1 and holds until `brk_clr` is sampled high. If a set and a clear occur in the same cycle, the set wins.
- R9: While `rst_n` is low, and after it is released, all outputs are 0 and the window is closed.
- R10: All three outputs change on the clock edge that samples the state they refer to, which is one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | A bus state is present this cycle |
| bus_addr | input | AW | Address of the bus state |
| bus_data | input | DW | Data of the bus state |
| bus_stat | input | SW | Status of the bus state |
| on_addr | input | AW | Start condition address value |
| on_addr_dc | input | AW | Start condition address don't-care mask |
| on_data | input | DW | Start condition data value |
| on_data_dc | input | DW | Start condition data don't-care mask |
| on_stat | input | SW | Start condition status value |
| on_stat_dc | input | SW | Start condition status don't-care mask |
| off_addr | input | AW | Stop condition address value |
| off_addr_dc | input | AW | Stop condition address don't-care mask |
| off_data | input | DW | Stop condition data value |
| off_data_dc | input | DW | Stop condition data don't-care mask |
| off_stat | input | SW | Stop condition status value |
| off_stat_dc | input | SW | Stop condition status don't-care mask |
| win_limit | input | CW | Maximum states per window, 0 means unlimited |
| brk_en | input | 1 | Break-on-trigger enable |
| brk_clr | input | 1 | Clears the sticky break request |
| store_en | output | 1 | Store the state sampled one cycle earlier |
| trig_pulse | output | 1 | One-clock trigger on a start match |
| brk_req | output | 1 | Sticky halt request toward run control |

## Verification
A wrong window state shows up on `store_en` one cycle after the next valid state. A window that fails to close keeps storing states that the reference says to drop. A window that fails to open drops the start state. A count that drifts shows as a window that ends one state early or late against the programmed limit, at the first state past the limit. A lost or stuck break flag shows on `brk_req` in the cycle after the start match or after the clear.

// File: rtl/tq_pkg.sv
package tq_pkg;

  typedef enum logic {
    WIN_CLOSED = 1'b0,
    WIN_OPEN   = 1'b1
  } win_e;

  localparam int unsigned N_COND = 2;
  localparam int unsigned COND_ON  = 0;
  localparam int unsigned COND_OFF = 1;

endpackage

// File: rtl/tq_matcher.sv
module tq_matcher #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] probe,
  input  logic [W-1:0] value,
  input  logic [W-1:0] dont_care,
  output logic         hit
);

  logic [W-1:0] diff;

  always_comb begin
    diff = (probe ^ value) & ~dont_care;
    hit  = (diff == '0);
  end

endmodule

// File: rtl/tq_cond.sv
module tq_cond #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 8,
  parameter int unsigned SW = 3
) (
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_data,
  input  logic [SW-1:0] bus_stat,
  input  logic [AW-1:0] c_addr,
  input  logic [AW-1:0] c_addr_dc,
  input  logic [DW-1:0] c_data,
  input  logic [DW-1:0] c_data_dc,
  input  logic [SW-1:0] c_stat,
  input  logic [SW-1:0] c_stat_dc,
  output logic          hit
);

  localparam int unsigned TW = AW + DW + SW;

  logic [TW-1:0] probe_all;
  logic [TW-1:0] value_all;
  logic [TW-1:0] dc_all;

  assign probe_all = {bus_addr, bus_data, bus_stat};
  assign value_all = {c_addr, c_data, c_stat};
  assign dc_all    = {c_addr_dc, c_data_dc, c_stat_dc};

  tq_matcher #(.W(TW)) u_cmp (
    .probe     (probe_all),
    .value     (value_all),
    .dont_care (dc_all),
    .hit       (hit)
  );

endmodule

// File: rtl/tq_window.sv
module tq_window
  import tq_pkg::*;
#(
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid,
  input  logic          on_hit,
  input  logic          off_hit,
  input  logic [CW-1:0] limit,
  output logic          store_q
);

  localparam int unsigned XW = CW + 1;

  win_e          st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          store_d;
  logic [XW-1:0] cnt_inc;
  logic          limit_on;
  logic          at_limit;

  always_comb begin
    cnt_inc  = {1'b0, cnt_q} + XW'(1);
    limit_on = (limit != '0);
    at_limit = limit_on && (cnt_inc >= {1'b0, limit});
  end

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    store_d = 1'b0;
    if (valid) begin
      if (st_q == WIN_OPEN) begin
        store_d = 1'b1;
        if (off_hit || at_limit) begin
          st_d  = WIN_CLOSED;
          cnt_d = '0;
        end else if (limit_on) begin
          cnt_d = cnt_inc[CW-1:0];
        end
      end else if (on_hit) begin
        store_d = 1'b1;
        if (off_hit || at_limit) begin
          st_d  = WIN_CLOSED;
          cnt_d = '0;
        end else begin
          st_d  = WIN_OPEN;
          cnt_d = limit_on ? cnt_inc[CW-1:0] : '0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= WIN_CLOSED;
      cnt_q   <= '0;
      store_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      store_q <= store_d;
    end
  end

  a_r2_start_stored: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && on_hit && st_q == WIN_CLOSED) |=> store_q);

  a_r3_stop_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && off_hit) |=> (st_q == WIN_CLOSED));

  a_r4_dual_hit_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && on_hit && off_hit && st_q == WIN_CLOSED) |=> (store_q && st_q == WIN_CLOSED));

  a_r5_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> (!store_q && $stable(st_q) && $stable(cnt_q)));

  a_r6_limit_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && st_q == WIN_OPEN && at_limit) |=> (st_q == WIN_CLOSED));

endmodule

// File: rtl/tq_break.sv
module tq_break (
  input  logic clk,
  input  logic rst_n,
  input  logic start_ev,
  input  logic brk_en,
  input  logic brk_clr,
  output logic trig_q,
  output logic brk_q
);

  logic brk_set;

  assign brk_set = start_ev && brk_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trig_q <= 1'b0;
      brk_q  <= 1'b0;
    end else begin
      trig_q <= start_ev;
      if (brk_set)
        brk_q <= 1'b1;
      else if (brk_clr)
        brk_q <= 1'b0;
    end
  end

  a_r7_trig_follows_event: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> trig_q);

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_q && !brk_clr) |=> brk_q);

  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ev && brk_en) |=> brk_q);

  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_clr && !(start_ev && brk_en)) |=> !brk_q);

  a_r8_no_set_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!brk_q && !(start_ev && brk_en)) |=> !brk_q);

endmodule

// File: rtl/trace_qualifier.sv
module trace_qualifier
  import tq_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 8,
  parameter int unsigned SW = 3,
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_valid,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_data,
  input  logic [SW-1:0] bus_stat,
  input  logic [AW-1:0] on_addr,
  input  logic [AW-1:0] on_addr_dc,
  input  logic [DW-1:0] on_data,
  input  logic [DW-1:0] on_data_dc,
  input  logic [SW-1:0] on_stat,
  input  logic [SW-1:0] on_stat_dc,
  input  logic [AW-1:0] off_addr,
  input  logic [AW-1:0] off_addr_dc,
  input  logic [DW-1:0] off_data,
  input  logic [DW-1:0] off_data_dc,
  input  logic [SW-1:0] off_stat,
  input  logic [SW-1:0] off_stat_dc,
  input  logic [CW-1:0] win_limit,
  input  logic          brk_en,
  input  logic          brk_clr,
  output logic          store_en,
  output logic          trig_pulse,
  output logic          brk_req
);

  logic [N_COND-1:0] hit;
  logic              start_ev;

  for (genvar g = 0; g < N_COND; g++) begin : g_cond
    tq_cond #(.AW(AW), .DW(DW), .SW(SW)) u_cond (
      .bus_addr  (bus_addr),
      .bus_data  (bus_data),
      .bus_stat  (bus_stat),
      .c_addr    ((g == COND_ON) ? on_addr    : off_addr),
      .c_addr_dc ((g == COND_ON) ? on_addr_dc : off_addr_dc),
      .c_data    ((g == COND_ON) ? on_data    : off_data),
      .c_data_dc ((g == COND_ON) ? on_data_dc : off_data_dc),
      .c_stat    ((g == COND_ON) ? on_stat    : off_stat),
      .c_stat_dc ((g == COND_ON) ? on_stat_dc : off_stat_dc),
      .hit       (hit[g])
    );
  end

  assign start_ev = bus_valid && hit[COND_ON];

  tq_window #(.CW(CW)) u_win (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid   (bus_valid),
    .on_hit  (hit[COND_ON]),
    .off_hit (hit[COND_OFF]),
    .limit   (win_limit),
    .store_q (store_en)
  );

  tq_break u_brk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_ev (start_ev),
    .brk_en   (brk_en),
    .brk_clr  (brk_clr),
    .trig_q   (trig_pulse),
    .brk_q    (brk_req)
  );

  a_r5_no_trig_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |=> !trig_pulse && !store_en);

  a_r1_full_dc_matches: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && (&on_addr_dc) && (&on_data_dc) && (&on_stat_dc)) |=> (trig_pulse && store_en));

endmodule

// File: tb/sim_trace_qualifier.sv
module sim_trace_qualifier;

  localparam int AW = 16, DW = 8, SW = 3, CW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_valid = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_data = '0;
  logic [SW-1:0] bus_stat = '0;
  logic [AW-1:0] on_addr = '0, on_addr_dc = '0, off_addr = '0, off_addr_dc = '0;
  logic [DW-1:0] on_data = '0, on_data_dc = '0, off_data = '0, off_data_dc = '0;
  logic [SW-1:0] on_stat = '0, on_stat_dc = '0, off_stat = '0, off_stat_dc = '0;
  logic [CW-1:0] win_limit = '0;
  logic brk_en = 1'b0, brk_clr = 1'b0;
  logic store_en, trig_pulse, brk_req;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  bit m_open = 0;
  int m_cnt = 0;
  bit m_brk = 0;

  always #4 clk = ~clk;

  trace_qualifier #(.AW(AW), .DW(DW), .SW(SW), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid),
    .bus_addr(bus_addr), .bus_data(bus_data), .bus_stat(bus_stat),
    .on_addr(on_addr), .on_addr_dc(on_addr_dc), .on_data(on_data),
    .on_data_dc(on_data_dc), .on_stat(on_stat), .on_stat_dc(on_stat_dc),
    .off_addr(off_addr), .off_addr_dc(off_addr_dc), .off_data(off_data),
    .off_data_dc(off_data_dc), .off_stat(off_stat), .off_stat_dc(off_stat_dc),
    .win_limit(win_limit), .brk_en(brk_en), .brk_clr(brk_clr),
    .store_en(store_en), .trig_pulse(trig_pulse), .brk_req(brk_req)
  );

  function automatic bit fmatch(logic [AW-1:0] a, logic [DW-1:0] d, logic [SW-1:0] s,
                                logic [AW-1:0] va, logic [AW-1:0] ma,
                                logic [DW-1:0] vd, logic [DW-1:0] md,
                                logic [SW-1:0] vs, logic [SW-1:0] ms);
    return (((a ^ va) & ~ma) == '0) && (((d ^ vd) & ~md) == '0) && (((s ^ vs) & ~ms) == '0);
  endfunction

  task automatic check(string tag, logic [2:0] act, logic [2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: {store,trig,brk} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Drive one bus state at a negedge, predict, and check one clock later.
  task automatic step(bit v, logic [AW-1:0] a, logic [DW-1:0] d, logic [SW-1:0] s,
                      bit clr, string tag);
    bit st, sp, e_store;
    int lim;
    bus_valid = v; bus_addr = a; bus_data = d; bus_stat = s; brk_clr = clr;
    lim = int'(win_limit);
    st = v && fmatch(a, d, s, on_addr, on_addr_dc, on_data, on_data_dc, on_stat, on_stat_dc);
    sp = v && fmatch(a, d, s, off_addr, off_addr_dc, off_data, off_data_dc, off_stat, off_stat_dc);
    e_store = 0;
    if (v) begin
      if (m_open) begin
        e_store = 1;
        if (sp || (lim != 0 && m_cnt + 1 >= lim)) begin m_open = 0; m_cnt = 0; end
        else if (lim != 0) m_cnt = m_cnt + 1;
      end else if (st) begin
        e_store = 1;
        if (sp || lim == 1) begin m_open = 0; m_cnt = 0; end
        else begin m_open = 1; m_cnt = (lim != 0) ? 1 : 0; end
      end
    end
    if (st && brk_en) m_brk = 1;
    else if (clr) m_brk = 0;
    @(negedge clk);
    check(tag, {store_en, trig_pulse, brk_req}, {e_store, st, m_brk});
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset", {store_en, trig_pulse, brk_req}, 3'b000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 after release", {store_en, trig_pulse, brk_req}, 3'b000);

    // R1/R7: status mask sweep, address must equal, data ignored, limit 1.
    on_addr = 16'h1234; on_addr_dc = '0; on_data_dc = '1; on_stat = 3'b101;
    off_addr = 16'hFFFF; off_addr_dc = '0; off_data_dc = '1; off_stat_dc = '1;
    win_limit = 4'd1;
    for (int m = 0; m < 8; m++) begin
      on_stat_dc = 3'(m);
      for (int s = 0; s < 8; s++) begin
        step(1, 16'h1234, 8'(s * 37), 3'(s), 0, "R1 status mask");
        step(1, 16'h1235, 8'(s), 3'(s), 0, "R1 address mismatch");
      end
    end

    // R2/R3/R5/R6/R7: window patterns for several limits.
    on_addr = 16'h0010; on_stat_dc = '1;
    off_addr = 16'h0020;
    for (int lim = 0; lim < 6; lim++) begin
      win_limit = 4'(lim);
      for (int k = 0; k < 12; k++) begin
        logic [AW-1:0] a;
        a = (k == 0 || k == 9 || k == 10) ? 16'h0010 :
            (k == 7 || k == 11) ? 16'h0020 : 16'(16'h0040 + k);
        step(k != 5, a, 8'(k * 7 + lim), 3'(k), 0,
             (k == 5) ? "R5 invalid cycle" : (lim != 0) ? "R6 window limit" :
             (k == 7 || k == 11) ? "R3 stop stored" : (k == 10) ? "R7 restart" : "R2 window");
      end
      step(1, 16'h0099, 8'h00, 3'd0, 0, "R3 closed after stop");
    end

    // R4: start and stop on the same state.
    win_limit = 4'd0;
    off_addr = 16'h0010;
    step(1, 16'h0010, 8'h11, 3'd1, 0, "R4 dual hit");
    step(1, 16'h0050, 8'h12, 3'd2, 0, "R4 stays closed");
    step(1, 16'h0051, 8'h13, 3'd2, 0, "R4 stays closed");
    off_addr = 16'h0020;

    // R8: sticky break request.
    brk_en = 1'b1;
    step(1, 16'h0010, 8'h01, 3'd0, 0, "R8 set");
    step(1, 16'h0030, 8'h02, 3'd0, 0, "R8 hold");
    step(0, 16'h0030, 8'h02, 3'd0, 0, "R8 hold idle");
    step(1, 16'h0020, 8'h03, 3'd0, 1, "R8 clear");
    step(1, 16'h0010, 8'h04, 3'd0, 1, "R8 set wins");
    step(1, 16'h0020, 8'h05, 3'd0, 0, "R8 hold");
    brk_en = 1'b0;
    step(1, 16'h0031, 8'h06, 3'd0, 1, "R8 clear");
    step(1, 16'h0010, 8'h07, 3'd0, 0, "R8 disabled");
    step(1, 16'h0020, 8'h08, 3'd0, 0, "R8 disabled");
    step(0, 16'h0010, 8'h09, 3'd0, 0, "R10 latency idle");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule